// File: doc/BRIEF.md
# Random Word Read-Interval Guard

This block sits between a hardware entropy source and whatever consumes its output. The source is modelled as a 32-bit input word. Every time the block takes a word from the source, it raises a one-cycle `src_take` strobe so the source can advance.

The guard enforces a minimum number of clock cycles between two takes. It publishes a `ready` flag that shows whether that interval has run out. It answers each read request with a registered response one cycle later. Once the source reports that it has been initialised, the guard throws away the first word on its own and starts the interval from that discard. Until this has happened, every request is turned away.

A request marked "wait" that arrives too early is not refused. It is held inside the block and served in the first cycle the interval allows.

Top module: `rng_gap_guard`

## Requirements
- R1: Two consecutive `src_take` pulses are never closer than `MIN_GAP` clock cycles. A take after a read can happen exactly `MIN_GAP` cycles after the previous take.
- R2: In the uninitialised state, an `src_init` pulse pulses `src_take` once in that same cycle. It produces no response, moves the block to normal operation and restarts the interval from that cycle.
- R3: In a cycle t after initialisation, `ready` is 1 if and only if t minus the cycle of the last take is at least `MIN_GAP`.
- R4: A request with `req_wait`=0 in a cycle where `ready` is 0 does not pulse `src_take`. One cycle later it gives `rsp_valid`=1, `rsp_refused`=1 and `rsp_data`=0.
- R5: A request with `req_wait`=1 in a cycle where `ready` is 0 gives no response while it waits. The take happens in the first cycle `ready` is 1, and the response follows one cycle after that take.
- R6: A request in a cycle where `ready` is 1 pulses `src_take` in that cycle. One cycle later it gives `rsp_valid`=1, `rsp_refused`=0 and `rsp_data` equal to `src_word` as it was in the take cycle. The take restarts the interval.
- R7: The interval counter saturates. After any idle period of `MIN_GAP` cycles or longer, `ready` stays at 1 and the next request is served.
- R8: After reset, `ready`, `rsp_valid` and `src_take` are 0. Until the initial discard has happened, every request is refused (`rsp_refused`=1), whatever the value of `req_wait`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the interval is counted in its cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| src_init | input | 1 | Pulse: entropy source has finished initialising |
| src_word | input | DATA_W | Current word presented by the entropy source |
| src_take | output | 1 | Strobe: the current word is consumed this cycle |
| req | input | 1 | Read request, one cycle per request |
| req_wait | input | 1 | With `req`: hold the request until the interval expires |
| ready | output | 1 | Interval since the last take has elapsed |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_refused | output | 1 | With `rsp_valid`: request was not served |
| rsp_data | output | DATA_W | With `rsp_valid`: word delivered (0 when refused) |

## Verification
The main function is exercised with immediate requests placed at every offset from two cycles up to a few cycles past the interval. These show that a request is refused before the boundary and served from it on. The same offsets are then used with waiting requests, to show that a held request finishes exactly at the boundary and never earlier. A long idle stretch checks that the saturating counter keeps the block ready. Requests before the initial discard, with and without the wait option, check that no word can escape before it.

// File: rtl/rng_gap_pkg.sv
package rng_gap_pkg;

    typedef enum logic [1:0] {
        ST_UNINIT = 2'd0,
        ST_RUN    = 2'd1,
        ST_STALL  = 2'd2
    } guard_state_e;

endpackage

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int MIN_GAP = 256,
    parameter int CNT_W   = $clog2(MIN_GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic gap_met
);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MIN_GAP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = CNT_W'(1);
        end else if (tmr_q.cnt != CAP) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign gap_met = (tmr_q.cnt == CAP);

    // R7
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= CAP);

    // R7
    stay_met_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_met && !restart) |=> gap_met);

endmodule

// File: rtl/read_ctrl.sv
module read_ctrl
    import rng_gap_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_init,
    input  logic [DATA_W-1:0] src_word,
    input  logic              req,
    input  logic              req_wait,
    input  logic              gap_met,
    output logic              src_take,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_refused,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        guard_state_e      state;
        logic              rsp_valid;
        logic              rsp_refused;
        logic [DATA_W-1:0] rsp_data;
    } ctrl_regs_t;

    ctrl_regs_t ctl_d, ctl_q;
    logic       take_d;

    always_comb begin
        ctl_d             = ctl_q;
        ctl_d.rsp_valid   = 1'b0;
        ctl_d.rsp_refused = 1'b0;
        ctl_d.rsp_data    = '0;
        take_d            = 1'b0;
        unique case (ctl_q.state)
            ST_UNINIT: begin
                if (req) begin
                    ctl_d.rsp_valid   = 1'b1;
                    ctl_d.rsp_refused = 1'b1;
                end
                if (src_init) begin
                    take_d      = 1'b1;
                    ctl_d.state = ST_RUN;
                end
            end
            ST_RUN: begin
                if (req) begin
                    if (gap_met) begin
                        take_d         = 1'b1;
                        ctl_d.rsp_valid = 1'b1;
                        ctl_d.rsp_data  = src_word;
                    end else if (req_wait) begin
                        ctl_d.state = ST_STALL;
                    end else begin
                        ctl_d.rsp_valid   = 1'b1;
                        ctl_d.rsp_refused = 1'b1;
                    end
                end
            end
            ST_STALL: begin
                if (gap_met) begin
                    take_d          = 1'b1;
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_data  = src_word;
                    ctl_d.state     = ST_RUN;
                end
            end
            default: ctl_d.state = ST_UNINIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_UNINIT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign src_take    = take_d;
    assign ready       = gap_met && (ctl_q.state != ST_UNINIT);
    assign rsp_valid   = ctl_q.rsp_valid;
    assign rsp_refused = ctl_q.rsp_refused;
    assign rsp_data    = ctl_q.rsp_data;

    // R1
    take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_take && ctl_q.state != ST_UNINIT) |-> gap_met);

    // R4
    refused_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_refused) |-> (rsp_data == '0));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_STALL && !gap_met) |=> (ctl_q.state == ST_STALL && !rsp_valid));

    // R8
    uninit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_UNINIT) |-> (!ready && !(rsp_valid && !rsp_refused)));

endmodule

// File: rtl/rng_gap_guard.sv
module rng_gap_guard #(
    parameter int DATA_W  = 32,
    parameter int MIN_GAP = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_init,
    input  logic [DATA_W-1:0] src_word,
    output logic              src_take,
    input  logic              req,
    input  logic              req_wait,
    output logic              ready,
    output logic              rsp_valid,
    output logic              rsp_refused,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int CNT_W = $clog2(MIN_GAP + 1);

    logic gap_met;
    logic take_w;

    gap_timer #(
        .MIN_GAP (MIN_GAP),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (take_w),
        .gap_met (gap_met)
    );

    read_ctrl #(
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_init    (src_init),
        .src_word    (src_word),
        .req         (req),
        .req_wait    (req_wait),
        .gap_met     (gap_met),
        .src_take    (take_w),
        .ready       (ready),
        .rsp_valid   (rsp_valid),
        .rsp_refused (rsp_refused),
        .rsp_data    (rsp_data)
    );

    assign src_take = take_w;

    // R6
    restart_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (MIN_GAP > 1 && src_take) |=> !ready);

endmodule

// File: tb/sim_rng_gap_guard.sv
`timescale 1ns/1ps
module sim_rng_gap_guard;
    localparam int GAP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_init = 1'b0;
    logic        req = 1'b0;
    logic        req_wait = 1'b0;
    logic [31:0] src_word;
    logic        src_take, ready, rsp_valid, rsp_refused;
    logic [31:0] rsp_data;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int last_take = 0;
    bit inited = 1'b0;
    bit have_take = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign src_word = 32'hC0DE_0000 ^ 32'(cyc);

    rng_gap_guard #(.DATA_W(32), .MIN_GAP(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .src_init(src_init), .src_word(src_word),
        .src_take(src_take), .req(req), .req_wait(req_wait), .ready(ready),
        .rsp_valid(rsp_valid), .rsp_refused(rsp_refused), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_ready();
        return inited && ((cyc - last_take) >= GAP);
    endfunction

    // per-cycle monitor, sampled 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            // R3: ready reflects the elapsed cycles since the last take
            chk(ready == exp_ready(), "R3", "ready", 32'(ready), 32'(exp_ready()));
            if (src_take) begin
                if (have_take) begin
                    // R1: spacing between takes
                    chk((cyc - last_take) >= GAP, "R1", "take spacing",
                        32'(cyc - last_take), 32'(GAP));
                end
                last_take = cyc;
                have_take = 1'b1;
            end
        end
    end

    task automatic read_nowait(output bit served);
        bit exp;
        int rc;
        @(negedge clk);
        req = 1'b1; req_wait = 1'b0;
        exp = exp_ready();
        rc = cyc;
        @(negedge clk);
        req = 1'b0;
        #2;
        chk(rsp_valid == 1'b1, exp ? "R6" : "R4", "rsp_valid", 32'(rsp_valid), 32'd1);
        chk(rsp_refused == !exp, exp ? "R6" : "R4", "rsp_refused",
            32'(rsp_refused), 32'(!exp));
        chk(rsp_data == (exp ? (32'hC0DE_0000 ^ 32'(rc)) : 32'd0),
            exp ? "R6" : "R4", "rsp_data", rsp_data,
            exp ? (32'hC0DE_0000 ^ 32'(rc)) : 32'd0);
        served = exp;
    endtask

    task automatic read_wait();
        int tc;
        int guard;
        @(negedge clk);
        req = 1'b1; req_wait = 1'b1;
        tc = exp_ready() ? cyc : (last_take + GAP);
        @(negedge clk);
        req = 1'b0; req_wait = 1'b0;
        #2;
        guard = 0;
        while (!rsp_valid && guard < 4 * GAP) begin
            @(negedge clk);
            #2;
            guard++;
        end
        // R5: held request completes at the interval boundary
        chk(cyc == tc + 1, "R5", "completion cycle", 32'(cyc), 32'(tc + 1));
        chk(rsp_valid && !rsp_refused, "R5", "served", 32'(rsp_refused), 32'd0);
        chk(rsp_data == (32'hC0DE_0000 ^ 32'(tc)), "R5", "data", rsp_data,
            32'hC0DE_0000 ^ 32'(tc));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit served;
        repeat (3) @(negedge clk);
        #1;
        // R8: reset state
        chk(!ready && !rsp_valid && !src_take, "R8", "reset outputs",
            {29'd0, ready, rsp_valid, src_take}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2 * GAP) @(negedge clk);

        // R8: requests before the discard are refused, with or without wait
        read_nowait(served);
        chk(!served, "R8", "pre-init no-wait", 32'(served), 32'd0);
        @(negedge clk);
        req = 1'b1; req_wait = 1'b1;
        @(negedge clk);
        req = 1'b0; req_wait = 1'b0;
        #2;
        chk(rsp_valid && rsp_refused, "R8", "pre-init wait refused",
            {30'd0, rsp_valid, rsp_refused}, 32'd3);

        // R2: initial discard
        @(negedge clk);
        src_init = 1'b1;
        #2;
        chk(src_take == 1'b1, "R2", "discard take", 32'(src_take), 32'd1);
        @(negedge clk);
        src_init = 1'b0;
        inited = 1'b1;
        #2;
        chk(rsp_valid == 1'b0, "R2", "no response for discard", 32'(rsp_valid), 32'd0);

        // R4/R6: immediate requests at each offset from a fresh take
        for (int off = 0; off <= GAP + 1; off++) begin
            read_wait();
            repeat (off) @(negedge clk);
            read_nowait(served);
        end

        // R5: waiting requests at each offset
        for (int off = 0; off <= GAP + 1; off++) begin
            read_wait();
            repeat (off) @(negedge clk);
            read_wait();
        end

        // R7: long idle, counter saturates and stays ready
        repeat (4 * GAP) @(negedge clk);
        #2;
        chk(ready == 1'b1, "R7", "ready after idle", 32'(ready), 32'd1);
        read_nowait(served);
        chk(served, "R7", "served after idle", 32'(served), 32'd1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule